// File: doc/BRIEF.md
# Quad-SPI Controller Command and Event Status Unit

This unit is the register-facing control slice of a quad-SPI memory controller. A 32-bit peripheral bus writes one-shot command bits that switch the controller on or off, reset its control state, or ask the serial engine to drop chip select once the current transfer finishes. The serial engine reports seven kinds of event as single-cycle pulses. The unit latches each one into a sticky flag that software can read.

Software picks which flags may raise the level interrupt. It does this by writing ones to a set register or to a clear register, and it reads the resulting mask back from a separate read-only location. Reading the status location returns the flags and clears them on the same clock. A pulse that arrives during that read is kept. A derived completion output goes high only once the instruction-end flag and the chip-select-rise flag are both pending. This lets a driver wait for a whole operation rather than one half of it.

Top module: `qspi_ctl_status`

## Requirements
- R1: While rst_n is low, every output is zero, and so are the status and mask read values.
- R2: A control write (offset 0x00) with bit 0 set raises ctl_enabled on the next cycle. With bit 1 set it lowers ctl_enabled. When both bits are set, ctl_enabled goes low. Nothing else changes ctl_enabled. Its level is reported in status bit 24.
- R3: A control write with bit 7 set clears the mask, all flags and ctl_enabled on the next cycle, overriding bit 0. Any event pulse in that same cycle is discarded, and ctl_soft_reset pulses high for exactly one cycle.
- R4: A control write with bit 24 set makes ctl_release_cs high for exactly the next cycle. It stays low after any cycle without such a write.
- R5: Each event pulse sets a sticky status flag on the next cycle, at these bit positions: receive full 0, transmit data empty 1, transmitter idle 2, overrun 3, chip-select rise 8, chip-select fall 9, instruction end 10. The flag stays set until it is cleared.
- R6: A read of the status location (offset 0x10) returns the flags plus the enabled level in bit 24. The same clock edge clears all flags, but it does not clear bit 24.
- R7: An event pulse that arrives in the same cycle as a status read is still set after that read.
- R8: Writing ones to offset 0x14 sets the matching mask bits, and writing ones to offset 0x18 clears them. Zero bits have no effect. Offset 0x1C reads the mask. Mask bits outside the seven flag positions read as zero, and writes to 0x1C are ignored.
- R9: irq is high exactly when some flag and its mask bit are both set. It is updated on the cycle after the change that caused it.
- R10: op_done is high exactly when both the instruction-end flag and the chip-select-rise flag are set. Neither flag alone raises it.
- R11: bus_rdata is zero for reads of offsets 0x00, 0x14 and 0x18, for reads of unmapped offsets, and whenever no read is in progress. A read is bus_sel high with bus_wr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| ev_rx_full | input | 1 | Receive data full pulse |
| ev_tx_ready | input | 1 | Transmit data empty pulse |
| ev_tx_idle | input | 1 | Transmitter idle pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_cs_rise | input | 1 | Chip-select deassertion pulse |
| ev_cs_fall | input | 1 | Chip-select assertion pulse |
| ev_instr_end | input | 1 | Instruction end pulse |
| ctl_enabled | output | 1 | Controller enabled level |
| ctl_release_cs | output | 1 | One-cycle request to release chip select |
| ctl_soft_reset | output | 1 | One-cycle software reset pulse |
| irq | output | 1 | Level interrupt |
| op_done | output | 1 | Instruction end and chip-select rise both pending |

## Verification
The properties assume one bus access per cycle, so a set-mask write, a clear-mask write and a status read can never coincide. They also assume that bus_wdata and the event pins are defined whenever bus_sel is high. The stimulus drives every input on the falling edge and holds it for a full cycle. It uses a directed phase that lines events up against status reads, enable/disable collisions and soft resets, and a pseudo-random phase that is restricted to the mapped offsets plus one unmapped offset. The pseudo-random phase keeps soft-reset writes rare so that the flags and the mask have time to build up between resets.

// File: rtl/qspi_ctl_pkg.sv
package qspi_ctl_pkg;
   localparam int unsigned EVT_N = 7;
   // Status positions of the sticky flags; the driver decodes these.
   localparam int unsigned EVT_POS [EVT_N] = '{0, 1, 2, 3, 8, 9, 10};
   localparam int unsigned EV_CSR  = 4;
   localparam int unsigned EV_IEND = 6;
   localparam int unsigned STAT_EN_POS = 24;
   localparam int unsigned CMD_EN_POS  = 0;
   localparam int unsigned CMD_DIS_POS = 1;
   localparam int unsigned CMD_RST_POS = 7;
   localparam int unsigned CMD_REL_POS = 24;

   typedef struct packed {
      logic release_cs;
      logic soft_rst;
      logic dis;
      logic en;
   } ctl_cmd_t;
endpackage

// File: rtl/qspi_ctl_cmd.sv
module qspi_ctl_cmd
   import qspi_ctl_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ctl_wr,
   input  ctl_cmd_t cmd,
   output logic     srst_now,
   output logic     enabled,
   output logic     release_pulse,
   output logic     srst_pulse
);
   assign srst_now = ctl_wr & cmd.soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled       <= 1'b0;
         release_pulse <= 1'b0;
         srst_pulse    <= 1'b0;
      end else begin
         release_pulse <= ctl_wr & cmd.release_cs;
         srst_pulse    <= srst_now;
         if (srst_now)
            enabled <= 1'b0;
         else if (ctl_wr && cmd.dis)
            enabled <= 1'b0;
         else if (ctl_wr && cmd.en)
            enabled <= 1'b1;
      end
   end
endmodule

// File: rtl/qspi_evt_sticky.sv
module qspi_evt_sticky #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic         rd_clr,
   input  logic [N-1:0] ev,
   output logic [N-1:0] flags
);
   generate
      if (N < 1) begin : g_bad_n
         $error("qspi_evt_sticky: N must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (clr_all)
            flags[i] <= 1'b0;
         else
            flags[i] <= (flags[i] & ~rd_clr) | ev[i];
      end
   end
endmodule

// File: rtl/qspi_irq_mask.sv
module qspi_irq_mask #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [N-1:0] bits,
   output logic [N-1:0] mask
);
   for (genvar i = 0; i < N; i++) begin : g_mbit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask[i] <= 1'b0;
         else if (clr_all)
            mask[i] <= 1'b0;
         else if (set_en && bits[i])
            mask[i] <= 1'b1;
         else if (clr_en && bits[i])
            mask[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/qspi_ctl_status.sv
module qspi_ctl_status
   import qspi_ctl_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] OFS_CTRL = 'h00,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h10,
   parameter logic [ADDR_W-1:0] OFS_IEN  = 'h14,
   parameter logic [ADDR_W-1:0] OFS_IDIS = 'h18,
   parameter logic [ADDR_W-1:0] OFS_IMSK = 'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_rx_full,
   input  logic              ev_tx_ready,
   input  logic              ev_tx_idle,
   input  logic              ev_overrun,
   input  logic              ev_cs_rise,
   input  logic              ev_cs_fall,
   input  logic              ev_instr_end,
   output logic              ctl_enabled,
   output logic              ctl_release_cs,
   output logic              ctl_soft_reset,
   output logic              irq,
   output logic              op_done
);
   localparam int unsigned TOP_BIT = (STAT_EN_POS > CMD_REL_POS) ? STAT_EN_POS : CMD_REL_POS;

   generate
      if (DATA_W <= TOP_BIT) begin : g_bad_width
         $error("qspi_ctl_status: DATA_W too narrow for the status layout");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("qspi_ctl_status: ADDR_W too narrow for the offsets");
      end
   endgenerate

   logic           wr_cyc, rd_cyc;
   logic           ctl_wr, stat_rd, ien_wr, idis_wr;
   ctl_cmd_t       cmd;
   logic           srst_now;
   logic [EVT_N-1:0] ev_vec, flags, mask, wbits;
   logic [DATA_W-1:0] stat_word, mask_word;
   logic           wdata_unused;

   assign wr_cyc  = bus_sel &  bus_wr;
   assign rd_cyc  = bus_sel & ~bus_wr;
   assign ctl_wr  = wr_cyc && (bus_addr == OFS_CTRL);
   assign ien_wr  = wr_cyc && (bus_addr == OFS_IEN);
   assign idis_wr = wr_cyc && (bus_addr == OFS_IDIS);
   assign stat_rd = rd_cyc && (bus_addr == OFS_STAT);
   assign wdata_unused = ^bus_wdata;

   assign cmd.en         = bus_wdata[CMD_EN_POS];
   assign cmd.dis        = bus_wdata[CMD_DIS_POS];
   assign cmd.soft_rst   = bus_wdata[CMD_RST_POS];
   assign cmd.release_cs = bus_wdata[CMD_REL_POS];

   assign ev_vec = {ev_instr_end, ev_cs_fall, ev_cs_rise, ev_overrun,
                    ev_tx_idle, ev_tx_ready, ev_rx_full};

   for (genvar i = 0; i < EVT_N; i++) begin : g_gather
      assign wbits[i] = bus_wdata[EVT_POS[i]];
   end

   qspi_ctl_cmd i_cmd (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_wr        (ctl_wr),
      .cmd           (cmd),
      .srst_now      (srst_now),
      .enabled       (ctl_enabled),
      .release_pulse (ctl_release_cs),
      .srst_pulse    (ctl_soft_reset)
   );

   qspi_evt_sticky #(.N(EVT_N)) i_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (srst_now),
      .rd_clr  (stat_rd),
      .ev      (ev_vec),
      .flags   (flags)
   );

   qspi_irq_mask #(.N(EVT_N)) i_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (srst_now),
      .set_en  (ien_wr),
      .clr_en  (idis_wr),
      .bits    (wbits),
      .mask    (mask)
   );

   always_comb begin
      stat_word = '0;
      mask_word = '0;
      for (int i = 0; i < int'(EVT_N); i++) begin
         stat_word[EVT_POS[i]] = flags[i];
         mask_word[EVT_POS[i]] = mask[i];
      end
      stat_word[STAT_EN_POS] = ctl_enabled;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_cyc) begin
         if (bus_addr == OFS_STAT)
            bus_rdata = stat_word;
         else if (bus_addr == OFS_IMSK)
            bus_rdata = mask_word;
      end
   end

   assign irq     = |(flags & mask);
   assign op_done = flags[EV_IEND] & flags[EV_CSR];
endmodule

// File: rtl/qspi_ctl_status_chk.sv
module qspi_ctl_status_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] OFS_CTRL = 'h00,
   parameter logic [ADDR_W-1:0] OFS_STAT = 'h10,
   parameter logic [ADDR_W-1:0] OFS_IDIS = 'h18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              ev_rx_full,
   input logic              ev_tx_ready,
   input logic              ev_tx_idle,
   input logic              ev_overrun,
   input logic              ev_cs_rise,
   input logic              ev_cs_fall,
   input logic              ev_instr_end,
   input logic              ctl_enabled,
   input logic              ctl_release_cs,
   input logic              ctl_soft_reset,
   input logic              irq,
   input logic              op_done
);
   logic c_ctl, c_rd_stat, c_any_ev, c_clr_all;
   assign c_ctl     = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
   assign c_rd_stat = bus_sel && !bus_wr && (bus_addr == OFS_STAT);
   assign c_clr_all = bus_sel && bus_wr && (bus_addr == OFS_IDIS) && (&bus_wdata);
   assign c_any_ev  = ev_rx_full | ev_tx_ready | ev_tx_idle | ev_overrun |
                      ev_cs_rise | ev_cs_fall | ev_instr_end;

   assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctl && bus_wdata[0] && !bus_wdata[1] && !bus_wdata[7] |=> ctl_enabled);
   assert_disable_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctl && bus_wdata[0] && bus_wdata[1] |=> !ctl_enabled);
   assert_enabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !c_ctl |=> $stable(ctl_enabled));
   assert_soft_reset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctl && bus_wdata[7] |=> ctl_soft_reset && !ctl_enabled && !irq && !op_done);
   assert_release_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctl && bus_wdata[24] |=> ctl_release_cs);
   assert_release_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(c_ctl && bus_wdata[24]) |=> !ctl_release_cs);
   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd_stat && !c_any_ev |=> !irq && !op_done);
   assert_pulse_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_instr_end && ev_cs_rise && !(c_ctl && bus_wdata[7]) |=> op_done);
   assert_unmasked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      c_clr_all |=> !irq);
endmodule

bind qspi_ctl_status qspi_ctl_status_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_CTRL(OFS_CTRL),
   .OFS_STAT(OFS_STAT), .OFS_IDIS(OFS_IDIS)
) i_chk (.*);

// File: tb/test_qspi_ctl_status.sv
module test_qspi_ctl_status;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EVMASK = 32'h0000_070F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [6:0]  ev = '0;
   logic [31:0] rdata;
   logic        en_o, rel_o, srst_o, irq_o, done_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // reference model state
   logic [31:0] m_flags = '0, m_mask = '0;
   logic        m_en = 0, m_rel = 0, m_srst = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qspi_ctl_status i_qspi_ctl_status (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata),
      .ev_rx_full(ev[0]), .ev_tx_ready(ev[1]), .ev_tx_idle(ev[2]),
      .ev_overrun(ev[3]), .ev_cs_rise(ev[4]), .ev_cs_fall(ev[5]),
      .ev_instr_end(ev[6]),
      .ctl_enabled(en_o), .ctl_release_cs(rel_o), .ctl_soft_reset(srst_o),
      .irq(irq_o), .op_done(done_o)
   );

   function automatic logic [31:0] ev_word(input logic [6:0] e);
      return {21'd0, e[6], e[5], e[4], 4'd0, e[3], e[2], e[1], e[0]};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_flags = '0; m_mask = '0; m_en = 0; m_rel = 0; m_srst = 0;
      end else begin
         logic ctl;
         ctl = sel && wr && addr == 8'h00;
         m_rel  = ctl && wdata[24];
         m_srst = ctl && wdata[7];
         if (m_srst) begin
            m_flags = '0; m_mask = '0; m_en = 0;
         end else begin
            if (sel && !wr && addr == 8'h10) m_flags = '0;
            m_flags = m_flags | ev_word(ev);
            if (ctl && wdata[1]) m_en = 0;
            else if (ctl && wdata[0]) m_en = 1;
            if (sel && wr && addr == 8'h14) m_mask = m_mask | (wdata & EVMASK);
            if (sel && wr && addr == 8'h18) m_mask = m_mask & ~wdata;
         end
      end
   end

   function automatic logic [31:0] exp_rdata();
      if (sel && !wr) begin
         if (addr == 8'h10) return m_flags | (32'(m_en) << 24);
         if (addr == 8'h1C) return m_mask;
      end
      return '0;
   endfunction

   function automatic string rd_tag();
      if (sel && !wr && addr == 8'h10) return "R6 status read";
      if (sel && !wr && addr == 8'h1C) return "R8 mask read";
      return "R11 zero read";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare();
      chk("R2 ctl_enabled", 32'(en_o), 32'(m_en));
      chk("R4 ctl_release_cs", 32'(rel_o), 32'(m_rel));
      chk("R3 ctl_soft_reset", 32'(srst_o), 32'(m_srst));
      chk("R9 irq", 32'(irq_o), 32'(|(m_flags & m_mask)));
      chk("R10 op_done", 32'(done_o), 32'(m_flags[10] & m_flags[8]));
      chk(rd_tag(), rdata, exp_rdata());
   endtask

   task automatic step(input logic s, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [6:0] e);
      @(negedge clk);
      compare();
      sel = s; wr = w; addr = a; wdata = d; ev = e;
   endtask

   task automatic peek(input string tag, input logic [31:0] exp);
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic idle(); step(0, 0, 8'h00, 0, 0); endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 enabled in reset", 32'(en_o), 0);
      chk("R1 irq in reset", 32'(irq_o), 0);
      chk("R1 op_done in reset", 32'(done_o), 0);
      sel = 1; wr = 0; addr = 8'h10;
      peek("R1 status in reset", 0);
      addr = 8'h1C;
      peek("R1 mask in reset", 0);
      sel = 0;
      @(negedge clk); rst_n = 1;

      // R2 enable, then collision
      step(1, 1, 8'h00, 32'h1, 0);
      step(1, 0, 8'h10, 0, 0);
      peek("R2 enabled bit 24", 32'h0100_0000);
      step(1, 1, 8'h00, 32'h3, 0);
      step(1, 0, 8'h10, 0, 0);
      peek("R2 disable wins", 32'h0);
      step(1, 1, 8'h00, 32'h1, 0);

      // R5 sticky flags, R6 clear on read
      step(0, 0, 8'h00, 0, 7'b0001001);
      idle();
      step(1, 0, 8'h10, 0, 0);
      peek("R5 overrun and rx full", 32'h0100_0009);
      step(1, 0, 8'h10, 0, 0);
      peek("R6 cleared, enabled kept", 32'h0100_0000);

      // R7 event during read
      step(1, 0, 8'h10, 0, 7'b0100000);
      step(1, 0, 8'h10, 0, 0);
      peek("R7 cs fall kept", 32'h0100_0200);

      // R8 mask set/clear/readback
      step(1, 1, 8'h14, 32'hFFFF_FFFF, 0);
      step(1, 0, 8'h1C, 0, 0);
      peek("R8 mask set", 32'h0000_070F);
      step(1, 1, 8'h18, 32'h0000_0001, 0);
      step(1, 1, 8'h1C, 32'h0, 0);
      step(1, 0, 8'h1C, 0, 0);
      peek("R8 mask after clear and ignored write", 32'h0000_070E);

      // R9 irq
      step(0, 0, 8'h00, 0, 7'b0001000);
      idle(); idle();
      step(1, 0, 8'h10, 0, 0);
      idle();

      // R10 op done
      step(1, 1, 8'h18, 32'hFFFF_FFFF, 7'b1000000);
      idle();
      step(0, 0, 8'h00, 0, 7'b0010000);
      idle(); idle();

      // R3 soft reset with enable and events
      step(1, 1, 8'h14, 32'h0000_0400, 0);
      step(1, 1, 8'h00, 32'h0000_0081, 7'b1111111);
      idle();
      step(1, 0, 8'h10, 0, 0);
      peek("R3 status after soft reset", 0);
      step(1, 0, 8'h1C, 0, 0);
      peek("R3 mask after soft reset", 0);

      // R4 release
      step(1, 1, 8'h00, 32'h0100_0000, 0);
      idle(); idle();

      // R11 write-only and unmapped reads
      step(1, 0, 8'h00, 0, 0); peek("R11 control read", 0);
      step(1, 0, 8'h14, 0, 0); peek("R11 enable read", 0);
      step(1, 0, 8'h18, 0, 0); peek("R11 disable read", 0);
      step(1, 0, 8'h04, 0, 0); peek("R11 unmapped read", 0);

      // pseudo-random phase
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r, d;
         logic [7:0] a;
         r = $urandom;
         case (r[10:8] % 6)
            0: a = 8'h00; 1: a = 8'h10; 2: a = 8'h14;
            3: a = 8'h18; 4: a = 8'h1C; default: a = 8'h04;
         endcase
         d = $urandom;
         if (r[15:12] != 0) d[7] = 1'b0;
         step(r[0] | r[1], r[2], a, d, 7'($urandom) & 7'($urandom));
      end
      idle();
      @(negedge clk);
      compare();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule